// File: doc/BRIEF.md
# Indexed Floating-Point Word Load Unit

This unit executes one instruction: a floating-point word load that forms its address from two integer registers. It takes a 32-bit instruction word, decodes it, and sends the base and index register selectors to the integer register file. The integer file returns the two register values on the same cycle. The unit adds the two values to form the effective address and checks that the address is word aligned. If the instruction is valid, the unit issues one word read on a simple valid/ready memory request channel.

When the read data returns, the unit writes the word into the low half of one 64-bit entry of its floating-point register file. The high half of that entry is not touched. A separate full-width write port lets other producers update whole entries. A combinational read port exposes any entry.

The unit reports two faults at the instruction level: a reserved-encoding flag and a misaligned-address flag. In both cases no memory access takes place. Instruction words that carry some other opcode are accepted and dropped without any effect.

Top module: `fpx_load_unit`

## Requirements
- R1: An instruction is a load only when bits 31..26 equal 6'b010011 and bits 5..0 equal 6'b000000. Any other word is accepted and ignored: it causes no memory request, no fault flag, no done pulse and no register change.
- R2: The memory address is the 32-bit sum of `base_val` and `index_val`, taken modulo 2^32. An overflow of the sum is not reported.
- R3: `base_sel` always equals instruction bits 25..21 and `index_sel` always equals bits 20..16. The destination register is chosen by bits 10..6.
- R4: For a load whose bits 15..11 are not all zero, `rsvd_err` is high for exactly the one cycle after acceptance. No memory request is made and no register is written. This check takes priority over the alignment check.
- R5: For a load with valid encoding whose address bits 1..0 are not both zero, `addr_err` is high for exactly the one cycle after acceptance. No memory request is made and no register is written.
- R6: For each valid load, `mem_rd_valid` rises in the cycle after acceptance. It stays high, with `mem_addr` unchanged, until the memory accepts it with `mem_rd_ready`. Exactly one read is issued per load.
- R7: The word that arrives with `mem_rsp_valid` goes into bits 31..0 of the destination entry. Bits 63..32 of that entry keep their previous value.
- R8: `done` is a one-cycle pulse in the cycle after the response is taken, and the new entry value is readable in that same cycle. `req_ready` is low from acceptance until that cycle.
- R9: After reset, `req_ready` is 1 and `mem_rd_valid`, `done`, `addr_err` and `rsvd_err` are 0. Every register entry reads zero.
- R10: When `fpr_wr_en` is high, the full 64-bit `fpr_wr_data` is written into entry `fpr_wr_idx` on that clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Instruction offered |
| req_ready | output | 1 | Unit idle, can take an instruction |
| instr | input | 32 | Instruction word |
| base_sel | output | 5 | Integer register selector for the base |
| index_sel | output | 5 | Integer register selector for the index |
| base_val | input | 32 | Base register value |
| index_val | input | 32 | Index register value |
| mem_rd_valid | output | 1 | Read request valid |
| mem_rd_ready | input | 1 | Memory takes the request |
| mem_addr | output | 32 | Read word address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 32 | Read data |
| done | output | 1 | Load completed pulse |
| addr_err | output | 1 | Misaligned address fault pulse |
| rsvd_err | output | 1 | Reserved encoding fault pulse |
| fpr_wr_en | input | 1 | Full-entry write enable |
| fpr_wr_idx | input | 5 | Full-entry write index |
| fpr_wr_data | input | 64 | Full-entry write data |
| fpr_rd_idx | input | 5 | Read port index |
| fpr_rd_data | output | 64 | Read port data |

## Verification
The bench uses the default parameters: 32-bit addresses and data, and 32 register entries. With these values it can sweep every destination entry, all four values of the low two address bits, and all 31 nonzero patterns in the reserved field. Every high half is first loaded with a distinct pattern, so any overwrite of a high half shows up. Address sums that carry out of bit 31, memory stalls of several lengths and response latencies of several lengths exercise the wrap-around and the request-hold behaviour.

// File: rtl/fpx_pkg.sv
package fpx_pkg;
  localparam int INSTR_W   = 32;
  localparam int REG_SEL_W = 5;
  localparam logic [5:0] OPC_IDX_LOAD = 6'b010011;
  localparam logic [5:0] FN_IDX_LOAD  = 6'b000000;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } fpx_state_e;
endpackage

// File: rtl/fpx_decode.sv
module fpx_decode
  import fpx_pkg::*;
(
  input  logic [INSTR_W-1:0]   instr,
  output logic                 is_load,
  output logic                 rsvd,
  output logic [REG_SEL_W-1:0] base_sel,
  output logic [REG_SEL_W-1:0] index_sel,
  output logic [REG_SEL_W-1:0] dest_sel
);
  always_comb begin
    is_load   = (instr[31:26] == OPC_IDX_LOAD) && (instr[5:0] == FN_IDX_LOAD);
    rsvd      = is_load && (instr[15:11] != 5'd0);
    base_sel  = instr[25:21];
    index_sel = instr[20:16];
    dest_sel  = instr[10:6];
  end
endmodule

// File: rtl/fpx_agen.sv
module fpx_agen #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32
) (
  input  logic [ADDR_W-1:0] base_val,
  input  logic [ADDR_W-1:0] index_val,
  output logic [ADDR_W-1:0] eff_addr,
  output logic              misaligned
);
  localparam int ALIGN_W = $clog2(DATA_W / 8);

  always_comb begin
    eff_addr   = base_val + index_val;
    misaligned = |eff_addr[ALIGN_W-1:0];
  end
endmodule

// File: rtl/fpx_fpr_file.sv
module fpx_fpr_file #(
  parameter int NUM_FPR = 32,
  parameter int HALF_W  = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       lo_we,
  input  logic [$clog2(NUM_FPR)-1:0] lo_idx,
  input  logic [HALF_W-1:0]          lo_data,
  input  logic                       full_we,
  input  logic [$clog2(NUM_FPR)-1:0] full_idx,
  input  logic [2*HALF_W-1:0]        full_data,
  input  logic [$clog2(NUM_FPR)-1:0] rd_idx,
  output logic [2*HALF_W-1:0]        rd_data
);
  localparam int IDX_W = $clog2(NUM_FPR);

  logic [HALF_W-1:0] lo_q [NUM_FPR];
  logic [HALF_W-1:0] hi_q [NUM_FPR];

  for (genvar i = 0; i < NUM_FPR; i++) begin : g_entry
    logic lo_hit, full_hit;
    assign lo_hit   = lo_we   && (lo_idx   == IDX_W'(i));
    assign full_hit = full_we && (full_idx == IDX_W'(i));

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        lo_q[i] <= '0;
        hi_q[i] <= '0;
      end else begin
        if (lo_hit)
          lo_q[i] <= lo_data;
        else if (full_hit)
          lo_q[i] <= full_data[HALF_W-1:0];
        if (full_hit)
          hi_q[i] <= full_data[2*HALF_W-1:HALF_W];
      end
    end
  end

  assign rd_data = {hi_q[rd_idx], lo_q[rd_idx]};
endmodule

// File: rtl/fpx_load_unit.sv
module fpx_load_unit
  import fpx_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int DATA_W  = 32,
  parameter int NUM_FPR = 32
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [INSTR_W-1:0]         instr,
  output logic [REG_SEL_W-1:0]       base_sel,
  output logic [REG_SEL_W-1:0]       index_sel,
  input  logic [ADDR_W-1:0]          base_val,
  input  logic [ADDR_W-1:0]          index_val,
  output logic                       mem_rd_valid,
  input  logic                       mem_rd_ready,
  output logic [ADDR_W-1:0]          mem_addr,
  input  logic                       mem_rsp_valid,
  input  logic [DATA_W-1:0]          mem_rsp_data,
  output logic                       done,
  output logic                       addr_err,
  output logic                       rsvd_err,
  input  logic                       fpr_wr_en,
  input  logic [$clog2(NUM_FPR)-1:0] fpr_wr_idx,
  input  logic [2*DATA_W-1:0]        fpr_wr_data,
  input  logic [$clog2(NUM_FPR)-1:0] fpr_rd_idx,
  output logic [2*DATA_W-1:0]        fpr_rd_data
);
  localparam int IDX_W = $clog2(NUM_FPR);

  // reset: asserted asynchronously, released through two flops
  logic [1:0] rst_sync_q;
  logic       rst_n_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  logic                 dec_load, dec_rsvd;
  logic [REG_SEL_W-1:0] dec_dest;
  logic [ADDR_W-1:0]    ea;
  logic                 ea_mis;

  fpx_decode u_dec (
    .instr    (instr),
    .is_load  (dec_load),
    .rsvd     (dec_rsvd),
    .base_sel (base_sel),
    .index_sel(index_sel),
    .dest_sel (dec_dest)
  );

  fpx_agen #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_agen (
    .base_val  (base_val),
    .index_val (index_val),
    .eff_addr  (ea),
    .misaligned(ea_mis)
  );

  fpx_state_e        state_q, state_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [IDX_W-1:0]  dest_q, dest_d;
  logic              done_q, done_d;
  logic              aerr_q, aerr_d;
  logic              rerr_q, rerr_d;
  logic              accept, addr_en, wr_lo;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d = state_q;
    addr_d  = addr_q;
    dest_d  = dest_q;
    addr_en = 1'b0;
    done_d  = 1'b0;
    aerr_d  = 1'b0;
    rerr_d  = 1'b0;
    wr_lo   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (accept && dec_load) begin
          if (dec_rsvd) begin
            rerr_d = 1'b1;
          end else if (ea_mis) begin
            aerr_d = 1'b1;
          end else begin
            addr_en = 1'b1;
            addr_d  = ea;
            dest_d  = dec_dest[IDX_W-1:0];
            state_d = ST_REQ;
          end
        end
      end
      ST_REQ: begin
        if (mem_rd_ready) state_d = ST_WAIT;
      end
      ST_WAIT: begin
        if (mem_rsp_valid) begin
          wr_lo   = 1'b1;
          done_d  = 1'b1;
          state_d = ST_IDLE;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      aerr_q  <= 1'b0;
      rerr_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      aerr_q  <= aerr_d;
      rerr_q  <= rerr_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      addr_q <= '0;
      dest_q <= '0;
    end else if (addr_en) begin
      addr_q <= addr_d;
      dest_q <= dest_d;
    end
  end

  fpx_fpr_file #(.NUM_FPR(NUM_FPR), .HALF_W(DATA_W)) u_fpr (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .lo_we    (wr_lo),
    .lo_idx   (dest_q),
    .lo_data  (mem_rsp_data),
    .full_we  (fpr_wr_en),
    .full_idx (fpr_wr_idx),
    .full_data(fpr_wr_data),
    .rd_idx   (fpr_rd_idx),
    .rd_data  (fpr_rd_data)
  );

  assign req_ready    = (state_q == ST_IDLE);
  assign mem_rd_valid = (state_q == ST_REQ);
  assign mem_addr     = addr_q;
  assign done         = done_q;
  assign addr_err     = aerr_q;
  assign rsvd_err     = rerr_q;

  AST_NO_READ_ON_FAULT: assert property (@(posedge clk) disable iff (!rst_n_s)
    (req_valid && req_ready && (dec_rsvd || (dec_load && ea_mis))) |=> !mem_rd_valid); // R5

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n_s)
    (mem_rd_valid && !mem_rd_ready) |=> (mem_rd_valid && $stable(mem_addr))); // R6

  AST_ADDR_ALIGNED: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_rd_valid |-> (mem_addr[1:0] == 2'b00)); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n_s)
    done |=> !done); // R8

  AST_FAULT_EXCL: assert property (@(posedge clk) disable iff (!rst_n_s)
    $countones({done, addr_err, rsvd_err}) <= 1); // R4

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n_s)
    mem_rd_valid |-> !req_ready); // R8
endmodule

// File: tb/fpx_load_unit_tb.sv
module fpx_load_unit_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid, req_ready;
  logic [31:0] instr;
  logic [4:0]  base_sel, index_sel;
  logic [31:0] base_val, index_val;
  logic        mem_rd_valid, mem_rd_ready;
  logic [31:0] mem_addr;
  logic        mem_rsp_valid;
  logic [31:0] mem_rsp_data;
  logic        done, addr_err, rsvd_err;
  logic        fpr_wr_en;
  logic [4:0]  fpr_wr_idx, fpr_rd_idx;
  logic [63:0] fpr_wr_data, fpr_rd_data;

  int checks = 0;
  int errors = 0;
  logic [63:0] model [32];

  always #5 clk = ~clk;

  fpx_load_unit u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .instr(instr), .base_sel(base_sel), .index_sel(index_sel),
    .base_val(base_val), .index_val(index_val),
    .mem_rd_valid(mem_rd_valid), .mem_rd_ready(mem_rd_ready), .mem_addr(mem_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data),
    .done(done), .addr_err(addr_err), .rsvd_err(rsvd_err),
    .fpr_wr_en(fpr_wr_en), .fpr_wr_idx(fpr_wr_idx), .fpr_wr_data(fpr_wr_data),
    .fpr_rd_idx(fpr_rd_idx), .fpr_rd_data(fpr_rd_data)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] enc(input logic [5:0] opc, input logic [4:0] b,
                                      input logic [4:0] x, input logic [4:0] z,
                                      input logic [4:0] d, input logic [5:0] fn);
    return {opc, b, x, z, d, fn};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, ~a[31:16]};
  endfunction

  task automatic check_entry(input string req, input int idx);
    fpr_rd_idx = 5'(idx);
    #1;
    chk(req, fpr_rd_data, model[idx]);
  endtask

  // kind: 0 valid load, 1 reserved, 2 misaligned, 3 ignored
  task automatic run(input logic [31:0] iw, input logic [31:0] b, input logic [31:0] x,
                     input int kind, input int stall, input int lat);
    logic [31:0] ea;
    logic [31:0] d;
    int dst;
    ea  = b + x;
    dst = int'(iw[10:6]);
    @(negedge clk);
    req_valid = 1'b1; instr = iw; base_val = b; index_val = x;
    #1;
    chk("R3 base_sel", 64'(base_sel), 64'(iw[25:21]));
    chk("R3 index_sel", 64'(index_sel), 64'(iw[20:16]));
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (kind == 1) begin
      chk("R4 rsvd_err", 64'({rsvd_err, addr_err, mem_rd_valid}), 64'b100);
      @(negedge clk);
      chk("R4 one cycle", 64'({rsvd_err, mem_rd_valid, done}), 64'b000);
      check_entry("R4 no write", dst);
    end else if (kind == 2) begin
      chk("R5 addr_err", 64'({rsvd_err, addr_err, mem_rd_valid}), 64'b010);
      @(negedge clk);
      chk("R5 one cycle", 64'({addr_err, mem_rd_valid, done}), 64'b000);
      check_entry("R5 no write", dst);
    end else if (kind == 3) begin
      chk("R1 ignored", 64'({rsvd_err, addr_err, mem_rd_valid, done, req_ready}), 64'b00001);
      @(negedge clk);
      chk("R1 ignored later", 64'({mem_rd_valid, done}), 64'b00);
      check_entry("R1 no write", dst);
    end else begin
      chk("R6 valid rises", 64'({mem_rd_valid, req_ready}), 64'b10);
      chk("R2 address", 64'(mem_addr), 64'(ea));
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R6 held", 64'({mem_rd_valid, mem_addr}), {31'd0, 1'b1, ea});
      end
      mem_rd_ready = 1'b1;
      @(posedge clk);
      @(negedge clk);
      mem_rd_ready = 1'b0;
      chk("R6 single read", 64'(mem_rd_valid), 64'd0);
      for (int l = 0; l < lat; l++) begin
        @(negedge clk);
        chk("R6 no second read", 64'({mem_rd_valid, done, req_ready}), 64'b000);
      end
      d = mem_word(ea);
      mem_rsp_valid = 1'b1; mem_rsp_data = d;
      @(posedge clk);
      @(negedge clk);
      mem_rsp_valid = 1'b0; mem_rsp_data = '0;
      model[dst][31:0] = d;
      chk("R8 done", 64'({done, req_ready}), 64'b11);
      check_entry("R7 low word, high kept", dst);
      @(negedge clk);
      chk("R8 done pulse", 64'(done), 64'd0);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : main
    rst_n = 1'b0; req_valid = 1'b0; instr = '0; base_val = '0; index_val = '0;
    mem_rd_ready = 1'b0; mem_rsp_valid = 1'b0; mem_rsp_data = '0;
    fpr_wr_en = 1'b0; fpr_wr_idx = '0; fpr_wr_data = '0; fpr_rd_idx = '0;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 reset outputs", 64'({req_ready, mem_rd_valid, done, addr_err, rsvd_err}), 64'b10000);
    for (int i = 0; i < 32; i++) check_entry("R9 entry zero", i);

    // R10 full-entry writes with distinct patterns
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      fpr_wr_en = 1'b1; fpr_wr_idx = 5'(i);
      fpr_wr_data = {32'hC0DE_0000 + 32'(i * 32'h0101), 32'hFFFF_0000 | 32'(i)};
      model[i] = fpr_wr_data;
    end
    @(negedge clk);
    fpr_wr_en = 1'b0;
    for (int i = 0; i < 32; i++) check_entry("R10 full write", i);

    // R7 every destination, aligned sums, varying stall and latency
    for (int d = 0; d < 32; d++)
      run(enc(6'b010011, 5'(d), 5'(31 - d), 5'd0, 5'(d), 6'b000000),
          32'h1000_0000 + 32'(d * 64), 32'(d * 4), 0, d % 3, d % 4);

    // R2 wrap-around of the sum
    run(enc(6'b010011, 5'd1, 5'd2, 5'd0, 5'd7, 6'd0), 32'hFFFF_FFF0, 32'h0000_0024, 0, 2, 1);
    run(enc(6'b010011, 5'd3, 5'd4, 5'd0, 5'd8, 6'd0), 32'h8000_0000, 32'h8000_0000, 0, 0, 0);

    // R5 all low-bit combinations
    for (int lo = 0; lo < 4; lo++)
      for (int k = 0; k < 4; k++)
        run(enc(6'b010011, 5'd5, 5'd6, 5'd0, 5'(k + 10), 6'd0),
            32'h0000_2000 + 32'(k * 3), 32'(lo - k * 3),
            (lo == 0) ? 0 : 2, 1, 1);

    // R4 every nonzero reserved field, including ones that would also be misaligned
    for (int z = 1; z < 32; z++)
      run(enc(6'b010011, 5'(z), 5'd2, 5'(z), 5'(z), 6'd0),
          32'h4000_0000, 32'(z % 4), 1, 0, 0);

    // R1 other opcodes and function codes
    run(enc(6'b010010, 5'd1, 5'd2, 5'd0, 5'd3, 6'd0), 32'h100, 32'h4, 3, 0, 0);
    run(enc(6'b010011, 5'd1, 5'd2, 5'd0, 5'd4, 6'b000001), 32'h100, 32'h4, 3, 0, 0);
    run(enc(6'b110001, 5'd1, 5'd2, 5'd9, 5'd5, 6'b100000), 32'h101, 32'h4, 3, 0, 0);
    run(enc(6'b010011, 5'd1, 5'd2, 5'd0, 5'd6, 6'b000101), 32'h100, 32'h1, 3, 0, 0);

    // final sweep: every entry matches the model
    for (int i = 0; i < 32; i++) check_entry("R7 final contents", i);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule